// File: doc/BRIEF.md
# Banked Byte and Bit Addressable Data Memory

This block is the internal data store of an 8-bit microcontroller core. One array of 256 bytes serves several address views at once. The lower 128 bytes are general RAM, reachable by direct or pointer-based (indirect) byte access. The upper 128 bytes form a special-register window that only direct access reaches. In this block that window is plain storage: the registers' own behaviour sits elsewhere.

A register port reads and writes one of eight working registers. The registers live in one of four banks at the bottom of RAM, and a two-bit bank value picks the bank. The core loads that value from its status word through a load strobe. A bit port reads, sets or clears one bit of a 256-entry bit space. The low half of that space covers the sixteen bytes starting at 20H. The high half covers the special registers whose byte address is a multiple of eight.

All reads are combinational from the current port inputs. Writes commit on the rising clock edge. When more than one port writes in the same cycle, a fixed priority picks the write that lands.

Top module: `banked_dram`

## Requirements
- R1: A direct byte write (byte_we_i=1, byte_ind_i=0) to any address 00H-FFH is stored at the clock edge. From the next cycle a direct read of that address returns the value.
- R2: An indirect access (byte_ind_i=1) to an address 00H-7FH reads and writes the same byte as a direct access to that address, and byte_err_o stays 0.
- R3: An indirect access to an address 80H-FFH drives byte_err_o=1 and byte_rdata_o=00H. A write made this way changes no byte.
- R4: The register port reaches byte bank*8+reg_idx_i. Bank code 0, 1, 2 and 3 gives base 00H, 08H, 10H and 18H.
- R5: The bank value resets to 0. It loads bank_sel_i on a clock edge where bank_ld_i=1 and holds its value on every other edge.
- R6: A bit address b below 80H selects bit (b mod 8) of byte 20H + (b div 8). Bytes 20H-2FH also stay byte-accessible.
- R7: A bit address b at or above 80H selects bit (b mod 8) of byte (b AND F8H).
- R8: A bit write (bit_we_i=1) stores bit_wval_i into the selected bit in one clock and leaves the other seven bits of that byte unchanged.
- R9: When several writes are requested in one cycle, only one commits. A byte write (unless blocked by R3) beats a register write, and a register write beats a bit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bank_sel_i | input | 2 | Bank code from the status word |
| bank_ld_i | input | 1 | Load strobe for the bank code |
| byte_addr_i | input | 8 | Byte address |
| byte_ind_i | input | 1 | 1 = indirect access, 0 = direct |
| byte_we_i | input | 1 | Byte write request |
| byte_wdata_i | input | 8 | Byte write data |
| byte_rdata_o | output | 8 | Byte read data |
| byte_err_o | output | 1 | Indirect access above the lower 128 bytes |
| reg_idx_i | input | 3 | Working-register index |
| reg_we_i | input | 1 | Register write request |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| bit_addr_i | input | 8 | Bit address |
| bit_we_i | input | 1 | Bit write request |
| bit_wval_i | input | 1 | Value to store in the addressed bit |
| bit_rdata_o | output | 1 | Addressed bit |

## Verification
The bench sweeps every byte address directly and indirectly. A design that let indirect accesses reach the upper window would return register contents instead of 00H, or overwrite them. It also walks all 256 bit addresses and checks the containing byte through the byte port after each toggle. A wrong mapping at the 7FH/80H seam, or a write that disturbs neighbouring bits, shows up there as a byte mismatch. Each bank is loaded and then written through the register port, so a bank offset error or a bank value that drifts without its load strobe lands in the wrong byte. Finally, colliding writes check that only the higher-priority port's data reaches the array.

// File: rtl/dram_pkg.sv
package dram_pkg;
  localparam int unsigned AW       = 8;
  localparam int unsigned DW       = 8;
  localparam int unsigned POS_W    = $clog2(DW);
  localparam int unsigned DEPTH    = 1 << AW;
  localparam logic [AW-1:0] BIT_BASE = 8'h20;

  typedef struct packed {
    logic          en;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/dram_bank_reg.sv
module dram_bank_reg #(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [BANK_W-1:0] sel_i,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_o <= '0;
    else if (ld_i) bank_o <= sel_i;
  end

  assert_bank_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> bank_o == $past(sel_i));
  assert_bank_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(bank_o));
endmodule

// File: rtl/dram_wr_arb.sv
module dram_wr_arb
  import dram_pkg::*;
(
  input  wr_req_t          byte_req_i,
  input  wr_req_t          reg_req_i,
  input  logic             bit_en_i,
  input  logic [AW-1:0]    bit_byte_i,
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic             bit_val_i,
  input  logic [DW-1:0]    bit_old_i,
  output wr_req_t          wr_o
);
  logic [DW-1:0] merged;

  // read-modify-write of the containing byte
  always_comb begin
    merged            = bit_old_i;
    merged[bit_pos_i] = bit_val_i;
  end

  always_comb begin
    if (byte_req_i.en)     wr_o = byte_req_i;
    else if (reg_req_i.en) wr_o = reg_req_i;
    else                   wr_o = '{en: bit_en_i, addr: bit_byte_i, data: merged};
  end
endmodule

// File: rtl/dram_store.sv
module dram_store
  import dram_pkg::*;
#(
  parameter int unsigned NRD = 3
) (
  input  logic                    clk_i,
  input  wr_req_t                 wr_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i.en) mem[wr_i.addr] <= wr_i.data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem[raddr_i[g]];
  end
endmodule

// File: rtl/banked_dram.sv
module banked_dram
  import dram_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_REGS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [$clog2(NUM_BANKS)-1:0]  bank_sel_i,
  input  logic                          bank_ld_i,
  input  logic [7:0]                    byte_addr_i,
  input  logic                          byte_ind_i,
  input  logic                          byte_we_i,
  input  logic [7:0]                    byte_wdata_i,
  output logic [7:0]                    byte_rdata_o,
  output logic                          byte_err_o,
  input  logic [$clog2(BANK_REGS)-1:0]  reg_idx_i,
  input  logic                          reg_we_i,
  input  logic [7:0]                    reg_wdata_i,
  output logic [7:0]                    reg_rdata_o,
  input  logic [7:0]                    bit_addr_i,
  input  logic                          bit_we_i,
  input  logic                          bit_wval_i,
  output logic                          bit_rdata_o
);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);
  localparam int unsigned IDX_W  = $clog2(BANK_REGS);
  localparam int unsigned PAD_W  = AW - BANK_W - IDX_W;

  logic [BANK_W-1:0]    bank_q;
  logic [AW-1:0]        reg_addr, bit_byte;
  logic [POS_W-1:0]     bit_pos;
  logic [2:0][AW-1:0]   raddr;
  logic [2:0][DW-1:0]   rdata;
  wr_req_t              byte_req, reg_req, wr;
  logic                 live_q;

  dram_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk_i, .rst_ni, .ld_i(bank_ld_i), .sel_i(bank_sel_i), .bank_o(bank_q));

  assign byte_err_o = byte_ind_i & byte_addr_i[AW-1];
  assign reg_addr   = {{PAD_W{1'b0}}, bank_q, reg_idx_i};
  assign bit_pos    = bit_addr_i[POS_W-1:0];
  // upper half: register at b & F8; lower half: bit window at 20H
  assign bit_byte   = bit_addr_i[AW-1] ? {bit_addr_i[AW-1:POS_W], {POS_W{1'b0}}}
                                       : BIT_BASE + AW'(bit_addr_i >> POS_W);

  assign raddr = {bit_byte, reg_addr, byte_addr_i};

  dram_store #(.NRD(3)) u_store (
    .clk_i, .wr_i(wr), .raddr_i(raddr), .rdata_o(rdata));

  assign byte_req = '{en: byte_we_i & ~byte_err_o, addr: byte_addr_i, data: byte_wdata_i};
  assign reg_req  = '{en: reg_we_i, addr: reg_addr, data: reg_wdata_i};

  dram_wr_arb u_arb (
    .byte_req_i(byte_req), .reg_req_i(reg_req),
    .bit_en_i(bit_we_i), .bit_byte_i(bit_byte), .bit_pos_i(bit_pos),
    .bit_val_i(bit_wval_i), .bit_old_i(rdata[2]), .wr_o(wr));

  assign byte_rdata_o = byte_err_o ? '0 : rdata[0];
  assign reg_rdata_o  = rdata[1];
  assign bit_rdata_o  = rdata[2][bit_pos];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_ind_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ind_i && byte_addr_i[AW-1]) |-> (byte_err_o && byte_rdata_o == '0));
  assert_ind_nowrite_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i && byte_err_o && !reg_we_i && !bit_we_i) |-> !wr.en);
  assert_byte_store_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(byte_we_i && !byte_err_o) && byte_addr_i == $past(byte_addr_i)
     && !byte_err_o) |-> byte_rdata_o == $past(byte_wdata_i));
  assert_bit_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(bit_we_i && !byte_we_i && !reg_we_i)
     && bit_addr_i == $past(bit_addr_i)) |-> bit_rdata_o == $past(bit_wval_i));
endmodule

// File: tb/banked_dram_test.sv
`timescale 1ns/1ps
module banked_dram_test;
  logic       clk = 0, rst_ni = 0;
  logic [1:0] bank_sel_i = 0;
  logic       bank_ld_i = 0;
  logic [7:0] byte_addr_i = 0, byte_wdata_i = 0, reg_wdata_i = 0, bit_addr_i = 0;
  logic       byte_ind_i = 0, byte_we_i = 0, reg_we_i = 0, bit_we_i = 0, bit_wval_i = 0;
  logic [2:0] reg_idx_i = 0;
  logic [7:0] byte_rdata_o, reg_rdata_o;
  logic       byte_err_o, bit_rdata_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_mem [256];

  always #2.5 clk = ~clk;

  banked_dram uut (.clk_i(clk), .rst_ni, .bank_sel_i, .bank_ld_i,
    .byte_addr_i, .byte_ind_i, .byte_we_i, .byte_wdata_i, .byte_rdata_o, .byte_err_o,
    .reg_idx_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .bit_addr_i, .bit_we_i, .bit_wval_i, .bit_rdata_o);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bmap(logic [7:0] b);
    return b >= 8'h80 ? (b & 8'hF8) : 8'h20 + (b >> 3);
  endfunction

  task automatic idle();
    byte_we_i = 0; reg_we_i = 0; bit_we_i = 0; bank_ld_i = 0;
  endtask

  task automatic commit();
    @(negedge clk); idle();
  endtask

  task automatic byte_wr(logic [7:0] a, logic ind, logic [7:0] d);
    @(negedge clk); byte_addr_i = a; byte_ind_i = ind; byte_wdata_i = d; byte_we_i = 1;
    commit();
  endtask

  task automatic byte_rd(logic [7:0] a, logic ind, output logic [7:0] d, output logic e);
    @(negedge clk); byte_addr_i = a; byte_ind_i = ind; #1; d = byte_rdata_o; e = byte_err_o;
  endtask

  task automatic load_bank(logic [1:0] k);
    @(negedge clk); bank_sel_i = k; bank_ld_i = 1; commit();
  endtask

  initial begin
    logic [7:0] d; logic e;
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic e;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R5 reset bank 0, R4 register view of bank 0
    for (int a = 0; a < 32; a++) begin
      exp_mem[a] = 8'hA0 + 8'(a);
      byte_wr(8'(a), 0, exp_mem[a]);
    end
    for (int n = 0; n < 8; n++) begin
      @(negedge clk); reg_idx_i = 3'(n); #1;
      chk("R5 reset bank0", reg_rdata_o, exp_mem[n]);
    end
    // R1 full direct sweep
    for (int a = 0; a < 256; a++) begin
      exp_mem[a] = 8'(a * 29 + 7);
      byte_wr(8'(a), 0, exp_mem[a]);
    end
    for (int a = 0; a < 256; a++) begin
      byte_rd(8'(a), 0, d, e);
      chk("R1 direct read", d, exp_mem[a]);
      chk("R1 direct err", {7'b0, e}, 8'h00);
    end
    // R2 / R3 indirect reads
    for (int a = 0; a < 256; a++) begin
      byte_rd(8'(a), 1, d, e);
      if (a < 128) begin
        chk("R2 indirect read", d, exp_mem[a]);
        chk("R2 indirect err", {7'b0, e}, 8'h00);
      end else begin
        chk("R3 indirect zero", d, 8'h00);
        chk("R3 indirect err", {7'b0, e}, 8'h01);
      end
    end
    // R2 indirect writes in the lower half
    for (int a = 'h30; a < 'h40; a++) begin
      exp_mem[a] = ~exp_mem[a];
      byte_wr(8'(a), 1, exp_mem[a]);
      byte_rd(8'(a), 0, d, e);
      chk("R2 indirect write", d, exp_mem[a]);
    end
    // R3 indirect writes above 7FH discarded
    foreach (exp_mem[a]) if (a >= 128 && (a % 17) == 0) begin
      byte_wr(8'(a), 1, 8'h5A ^ exp_mem[a]);
      byte_rd(8'(a), 0, d, e);
      chk("R3 indirect write ignored", d, exp_mem[a]);
    end
    // R4 / R5 each bank through the register port
    for (int k = 0; k < 4; k++) begin
      load_bank(2'(k));
      for (int n = 0; n < 8; n++) begin
        @(negedge clk); reg_idx_i = 3'(n); reg_wdata_i = 8'(k * 16 + n + 'h40); reg_we_i = 1;
        exp_mem[k*8+n] = reg_wdata_i;
        commit();
        byte_rd(8'(k*8+n), 0, d, e);
        chk("R4 reg write lands at bank*8+idx", d, exp_mem[k*8+n]);
        #1; chk("R4 reg read", reg_rdata_o, exp_mem[k*8+n]);
      end
    end
    // R5 bank holds without load strobe
    @(negedge clk); bank_sel_i = 2'd1; reg_idx_i = 3'd2;
    @(negedge clk); #1;
    chk("R5 bank holds", reg_rdata_o, exp_mem[8'h1A]);
    load_bank(2'd0);
    #1; chk("R5 bank reload", reg_rdata_o, exp_mem[8'h02]);
    // R6 / R7 / R8 full bit sweep
    for (int b = 0; b < 256; b++) begin
      logic [7:0] ba; logic cur;
      ba = bmap(8'(b));
      cur = exp_mem[ba][b % 8];
      @(negedge clk); bit_addr_i = 8'(b); #1;
      chk(b < 128 ? "R6 bit read" : "R7 bit read", {7'b0, bit_rdata_o}, {7'b0, cur});
      bit_wval_i = ~cur; bit_we_i = 1;
      exp_mem[ba][b % 8] = ~cur;
      commit();
      byte_rd(ba, 0, d, e);
      chk("R8 bit write byte view", d, exp_mem[ba]);
      #1; chk("R8 bit readback", {7'b0, bit_rdata_o}, {7'b0, ~cur});
    end
    // R9 byte beats bit on same byte (bit 28H -> byte 25H bit 0)
    @(negedge clk); byte_addr_i = 8'h25; byte_ind_i = 0; byte_wdata_i = 8'h3C; byte_we_i = 1;
    bit_addr_i = 8'h28; bit_wval_i = 1; bit_we_i = 1;
    exp_mem[8'h25] = 8'h3C; commit();
    byte_rd(8'h25, 0, d, e); chk("R9 byte over bit", d, exp_mem[8'h25]);
    // R9 reg beats bit
    @(negedge clk); reg_idx_i = 3'd5; reg_wdata_i = 8'hC3; reg_we_i = 1;
    bit_addr_i = 8'h0B; bit_wval_i = ~exp_mem[8'h21][3]; bit_we_i = 1;
    exp_mem[8'h05] = 8'hC3; commit();
    byte_rd(8'h21, 0, d, e); chk("R9 bit dropped under reg", d, exp_mem[8'h21]);
    byte_rd(8'h05, 0, d, e); chk("R9 reg over bit", d, exp_mem[8'h05]);
    // R9 byte beats reg
    @(negedge clk); byte_addr_i = 8'h40; byte_wdata_i = 8'h99; byte_we_i = 1;
    reg_idx_i = 3'd1; reg_wdata_i = 8'h66; reg_we_i = 1;
    exp_mem[8'h40] = 8'h99; commit();
    byte_rd(8'h40, 0, d, e); chk("R9 byte over reg", d, exp_mem[8'h40]);
    byte_rd(8'h01, 0, d, e); chk("R9 reg dropped under byte", d, exp_mem[8'h01]);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule